// File: doc/BRIEF.md
# Dual-Bank Pointer Address Generator

This block keeps the eight 8-bit pointer registers of a small DSP and turns an indirect operand request into a data RAM address. Pointers 0 to 3 belong to data bank 0 and pointers 4 to 7 to data bank 1. The instruction word selects the bank, the pointer and a 2-bit post-modify code. A single-level access can leave the pointer alone, step it up or step it down. The step can wrap inside a power-of-two window, whose size comes from a 3-bit loop-size field of the status word. Pointers 3 and 7 are hardwired. For these two, the modify code instead selects a fixed word 0 to 3 of their bank.

A second indirection level is also handled. The RAM word at the pointer is handed out as a program-memory address, and the same RAM word is written back one higher. The RAM arrays sit outside the block, and their read data comes back within the same cycle. Every result appears combinationally in the cycle of the request, and pointer updates take effect at the next clock edge. A direct load port writes a pointer from the low byte of an immediate or register value. A read port returns any pointer.

Top module: `dual_bank_ptr_agu`

## Requirements
- R1: After reset every pointer reads 0, and with no request all access outputs (ramEn, ramBank, ramAddr, ramWe, ramWrData, pmEn, pmAddr, accErr) are 0.
- R2: A request with accValid=1 drives ramEn=1 and ramBank=opWord[8]. For pointer index opWord[1:0] of 0 to 2, it drives ramAddr equal to the value of pointer {opWord[8],opWord[1:0]} before any update.
- R3: Modify code opWord[3:2]=00 leaves the pointer unchanged. Code 01 adds 1 modulo 256 whatever the loop size.
- R4: Code 11 adds 1. When loopSize (3 bits) is nonzero, only the low loopSize bits count and wrap, and the upper bits are kept. When loopSize is 0, the add is plain modulo 256.
- R5: Code 10 subtracts 1, with the same wrap rule as R4.
- R6: Pointers 3 and 7 always read 0 and ignore loads and modify codes. An access through them gives ramAddr = opWord[3:2] (word 0 to 3 of the bank).
- R7: A request with accDouble=1 gives pmEn=1, pmAddr=ramRdData, ramWe=1 and ramWrData=ramRdData+1 (modulo 2^16), at the same ramAddr as R2/R6. The pointer is unchanged.
- R8: A double-level request on pointers 0 to 2 or 4 to 6 with a nonzero modify code raises accErr for that cycle only. It gives ramEn=0, ramWe=0 and pmEn=0 and changes no pointer.
- R9: ldEn=1 writes ldData[7:0] into pointer ldIdx at the next edge. If the same pointer is also post-modified in that cycle, the load wins.
- R10: rdPtr shows the current value of pointer rdIdx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Indirect access request this cycle |
| accDouble | input | 1 | 1 = second indirection level |
| opWord | input | 16 | Instruction word: bank bit 8, modify bits 3:2, pointer bits 1:0 |
| loopSize | input | 3 | Modulo window exponent, 0 = no wrap window |
| ldEn | input | 1 | Direct pointer load strobe |
| ldIdx | input | 3 | Pointer to load |
| ldData | input | 16 | Load value, low byte used |
| rdIdx | input | 3 | Pointer to read back |
| rdPtr | output | 8 | Value of pointer rdIdx |
| ramEn | output | 1 | Data RAM access enable |
| ramBank | output | 1 | Data RAM bank select |
| ramAddr | output | 8 | Data RAM word address |
| ramRdData | input | 16 | Data RAM read word, same cycle |
| ramWe | output | 1 | Data RAM write-back enable |
| ramWrData | output | 16 | Data RAM write-back word |
| pmEn | output | 1 | Program-memory address valid |
| pmAddr | output | 16 | Program-memory address |
| accErr | output | 1 | Invalid double-level modifier |

## Verification
The pointer arithmetic is driven at positions chosen to separate the wrap rules. 0xFF with code 01 under a small window must reach 0x00, not wrap inside the window. 0x07 and 0x3F with code 11 must fold back to the base of their window and keep the upper bits. 0x30 with code 10 must fold up to the top of its window, and 0x80 and 0x81 with loop size 0 must step across the byte plainly. The hardwired pointers get all four modify codes and load attempts, so a fixed-word decode can be told apart from a real pointer. Double-level reads are repeated on the same word, including 0xFFFF, to show both the write-back increment and its 16-bit wrap. A load that collides with a post-modify on the same pointer shows which one wins.

// File: rtl/agu_pkg.sv
package agu_pkg;
  // Instruction field positions (decoded by the control)
  localparam int BANK_BIT = 8;
  localparam int MOD_LSB  = 2;
  localparam int IDX_LSB  = 0;
  localparam int PER_BANK = 4;
  localparam int NUM_PTR  = 2 * PER_BANK;
  localparam int SEL_W    = $clog2(NUM_PTR);
  localparam int IDX_W    = $clog2(PER_BANK);

  typedef enum logic [1:0] {
    MOD_HOLD     = 2'b00,
    MOD_INC_FREE = 2'b01,
    MOD_DEC      = 2'b10,
    MOD_INC_LOOP = 2'b11
  } modCode_e;

  typedef struct packed {
    logic             accEn;
    logic             bankSel;
    logic [IDX_W-1:0] ptrIdx;
    logic             isFixed;
    modCode_e         modCode;
    logic             ptrUpd;
    logic             memBump;
    logic             errPulse;
  } aguCtl_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              accValid,
  input  logic              accDouble,
  input  logic [DATA_W-1:0] opWord,
  output aguCtl_t           ctl
);
  logic [IDX_W-1:0] idxField;
  modCode_e         modField;
  logic             fixedSel;
  logic             badMode;

  always_comb begin
    idxField = opWord[IDX_LSB +: IDX_W];
    modField = modCode_e'(opWord[MOD_LSB +: 2]);
    fixedSel = (idxField == IDX_W'(PER_BANK - 1));
    badMode  = accValid && accDouble && !fixedSel && (modField != MOD_HOLD);

    ctl.bankSel  = opWord[BANK_BIT];
    ctl.ptrIdx   = idxField;
    ctl.isFixed  = fixedSel;
    ctl.modCode  = modField;
    ctl.errPulse = badMode;
    ctl.accEn    = accValid && !badMode;
    ctl.memBump  = accValid && accDouble && !badMode;
    ctl.ptrUpd   = accValid && !accDouble && !fixedSel && (modField != MOD_HOLD);
  end
endmodule

// File: rtl/agu_dpath.sv
module agu_dpath
  import agu_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 16,
  parameter int LOOP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguCtl_t           ctl,
  input  logic [LOOP_W-1:0] loopSize,
  input  logic              ldEn,
  input  logic [SEL_W-1:0]  ldIdx,
  input  logic [DATA_W-1:0] ldData,
  input  logic [SEL_W-1:0]  rdIdx,
  output logic [PTR_W-1:0]  rdPtr,
  output logic              ramEn,
  output logic              ramBank,
  output logic [PTR_W-1:0]  ramAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWrData,
  output logic              pmEn,
  output logic [DATA_W-1:0] pmAddr
);
  localparam logic [PTR_W-1:0]  PTR_ONE  = PTR_W'(1);
  localparam logic [DATA_W-1:0] DATA_ONE = DATA_W'(1);

  logic [PTR_W-1:0] ptrQ [NUM_PTR];
  logic [SEL_W-1:0] selIdx;
  logic [PTR_W-1:0] curPtr;
  logic [PTR_W-1:0] wrapMask;
  logic [PTR_W-1:0] nextPtr;
  logic [PTR_W-1:0] effAddr;

  assign selIdx = {ctl.bankSel, ctl.ptrIdx};
  assign curPtr = ptrQ[selIdx];

  // Bits inside the loop window; all bits when the window is off
  always_comb begin
    for (int b = 0; b < PTR_W; b++) begin
      wrapMask[b] = (loopSize == '0) || (b < int'(loopSize));
    end
  end

  always_comb begin
    case (ctl.modCode)
      MOD_INC_FREE: nextPtr = curPtr + PTR_ONE;
      MOD_INC_LOOP: nextPtr = (curPtr & ~wrapMask) | ((curPtr + PTR_ONE) & wrapMask);
      MOD_DEC:      nextPtr = (curPtr & ~wrapMask) | ((curPtr - PTR_ONE) & wrapMask);
      default:      nextPtr = curPtr;
    endcase
  end

  // Pointer file: the last pointer of each bank is a hardwired base
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    if ((g % PER_BANK) == PER_BANK - 1) begin : g_fixed
      assign ptrQ[g] = '0;
    end else begin : g_live
      logic [PTR_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          q <= '0;
        end else if (ldEn && (ldIdx == SEL_W'(g))) begin
          q <= ldData[PTR_W-1:0];
        end else if (ctl.ptrUpd && (selIdx == SEL_W'(g))) begin
          q <= nextPtr;
        end
      end
      assign ptrQ[g] = q;
    end
  end

  assign rdPtr   = ptrQ[rdIdx];
  assign effAddr = ctl.isFixed ? PTR_W'(ctl.modCode) : curPtr;

  always_comb begin
    ramEn     = ctl.accEn;
    ramBank   = ctl.accEn ? ctl.bankSel : 1'b0;
    ramAddr   = ctl.accEn ? effAddr : '0;
    pmEn      = ctl.memBump;
    ramWe     = ctl.memBump;
    pmAddr    = ctl.memBump ? ramRdData : '0;
    ramWrData = ctl.memBump ? ramRdData + DATA_ONE : '0;
  end
endmodule

// File: rtl/dual_bank_ptr_agu.sv
module dual_bank_ptr_agu
  import agu_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 16,
  parameter int LOOP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accDouble,
  input  logic [DATA_W-1:0] opWord,
  input  logic [LOOP_W-1:0] loopSize,
  input  logic              ldEn,
  input  logic [SEL_W-1:0]  ldIdx,
  input  logic [DATA_W-1:0] ldData,
  input  logic [SEL_W-1:0]  rdIdx,
  output logic [PTR_W-1:0]  rdPtr,
  output logic              ramEn,
  output logic              ramBank,
  output logic [PTR_W-1:0]  ramAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWrData,
  output logic              pmEn,
  output logic [DATA_W-1:0] pmAddr,
  output logic              accErr
);
  aguCtl_t ctl;

  agu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .accValid (accValid),
    .accDouble(accDouble),
    .opWord   (opWord),
    .ctl      (ctl)
  );

  agu_dpath #(.PTR_W(PTR_W), .DATA_W(DATA_W), .LOOP_W(LOOP_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .loopSize (loopSize),
    .ldEn     (ldEn),
    .ldIdx    (ldIdx),
    .ldData   (ldData),
    .rdIdx    (rdIdx),
    .rdPtr    (rdPtr),
    .ramEn    (ramEn),
    .ramBank  (ramBank),
    .ramAddr  (ramAddr),
    .ramRdData(ramRdData),
    .ramWe    (ramWe),
    .ramWrData(ramWrData),
    .pmEn     (pmEn),
    .pmAddr   (pmAddr)
  );

  assign accErr = ctl.errPulse;
endmodule

// File: rtl/agu_chk.sv
module agu_chk
  import agu_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accDouble,
  input logic [DATA_W-1:0] opWord,
  input logic              ldEn,
  input logic [SEL_W-1:0]  rdIdx,
  input logic [PTR_W-1:0]  rdPtr,
  input logic              ramEn,
  input logic              ramWe,
  input logic [DATA_W-1:0] ramWrData,
  input logic              pmEn,
  input logic [DATA_W-1:0] pmAddr,
  input logic              accErr
);
  // R8
  err_blocks_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (!ramEn && !ramWe && !pmEn));

  // R7
  mem_bump_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmEn |-> (ramWe && ramEn && (ramWrData == pmAddr + DATA_W'(1))));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!ramEn && !ramWe && !pmEn && !accErr));

  // R6
  fixed_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx[IDX_W-1:0] == IDX_W'(PER_BANK - 1)) |-> (rdPtr == '0));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!ldEn && (!accValid || accDouble || accErr || (opWord[MOD_LSB +: 2] == 2'b00)))
     && $stable(rdIdx)) |-> $stable(rdPtr));
endmodule

bind dual_bank_ptr_agu agu_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .accDouble(accDouble),
  .opWord   (opWord),
  .ldEn     (ldEn),
  .rdIdx    (rdIdx),
  .rdPtr    (rdPtr),
  .ramEn    (ramEn),
  .ramWe    (ramWe),
  .ramWrData(ramWrData),
  .pmEn     (pmEn),
  .pmAddr   (pmAddr),
  .accErr   (accErr)
);

// File: tb/tb_dual_bank_ptr_agu.sv
`timescale 1ns/1ps
module tb_dual_bank_ptr_agu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accDouble = 1'b0;
  logic [15:0] opWord = '0;
  logic [2:0]  loopSize = '0;
  logic        ldEn = 1'b0;
  logic [2:0]  ldIdx = '0;
  logic [15:0] ldData = '0;
  logic [2:0]  rdIdx = '0;
  logic [7:0]  rdPtr;
  logic        ramEn, ramBank, ramWe, pmEn, accErr;
  logic [7:0]  ramAddr;
  logic [15:0] ramRdData, ramWrData, pmAddr;

  always #2.5 clk = ~clk;

  dual_bank_ptr_agu dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accDouble(accDouble),
    .opWord(opWord), .loopSize(loopSize), .ldEn(ldEn), .ldIdx(ldIdx),
    .ldData(ldData), .rdIdx(rdIdx), .rdPtr(rdPtr), .ramEn(ramEn),
    .ramBank(ramBank), .ramAddr(ramAddr), .ramRdData(ramRdData),
    .ramWe(ramWe), .ramWrData(ramWrData), .pmEn(pmEn), .pmAddr(pmAddr),
    .accErr(accErr)
  );

  // External data RAM, combinational read
  logic [15:0] ramMem [512];
  assign ramRdData = ramMem[{ramBank, ramAddr}];
  always @(posedge clk) if (ramWe) ramMem[{ramBank, ramAddr}] <= ramWrData;

  typedef struct {
    logic        ramEn;
    logic        ramBank;
    logic [7:0]  ramAddr;
    logic        ramWe;
    logic [15:0] ramWrData;
    logic        pmEn;
    logic [15:0] pmAddr;
    logic        accErr;
    logic [7:0]  rdPtr;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  logic [7:0] mdl [8];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic logic [15:0] mkOp(input logic bank, input logic [1:0] md, input logic [1:0] idx);
    return {7'b0, bank, 4'b0, md, idx};
  endfunction

  function automatic logic [7:0] stepPtr(input logic [7:0] p, input logic [1:0] md, input logic [2:0] ls);
    int period, low, lowN;
    if (md == 2'b01) return p + 8'd1;
    if (ls == 0) return (md == 2'b11) ? p + 8'd1 : p - 8'd1;
    period = 1 << ls;
    low = int'(p) % period;
    lowN = (md == 2'b11) ? (low + 1) % period : (low + period - 1) % period;
    return 8'(int'(p) - low + lowN);
  endfunction

  // Driver: applies one cycle of stimulus and queues its expected result
  task automatic doCycle(input string tag, input logic aV, input logic dbl, input logic [15:0] op,
                         input logic [2:0] ls, input logic lE, input logic [2:0] lI,
                         input logic [15:0] lD, input logic [2:0] rI);
    exp_t e;
    logic bank, fixed, err;
    logic [1:0] md, idx;
    logic [7:0] base;
    logic [15:0] word;
    @(posedge clk); #1;
    accValid = aV; accDouble = dbl; opWord = op; loopSize = ls;
    ldEn = lE; ldIdx = lI; ldData = lD; rdIdx = rI;
    bank = op[8]; md = op[3:2]; idx = op[1:0];
    fixed = (idx == 2'b11);
    base = fixed ? {6'b0, md} : mdl[{bank, idx}];
    err = aV && dbl && !fixed && (md != 2'b00);
    e.tag = tag;
    e.accErr = err;
    e.ramEn = aV && !err;
    e.ramBank = e.ramEn ? bank : 1'b0;
    e.ramAddr = e.ramEn ? base : 8'h00;
    e.pmEn = e.ramEn && dbl;
    e.ramWe = e.pmEn;
    word = ramMem[{bank, base}];
    e.pmAddr = e.pmEn ? word : 16'h0;
    e.ramWrData = e.pmEn ? word + 16'd1 : 16'h0;
    e.rdPtr = mdl[rI];
    expQ.push_back(e);
    if (aV && !dbl && !fixed && md != 2'b00) mdl[{bank, idx}] = stepPtr(base, md, ls);
    if (lE && lI[1:0] != 2'b11) mdl[lI] = lD[7:0];
  endtask

  task automatic idle(input string tag, input logic [2:0] rI);
    doCycle(tag, 1'b0, 1'b0, 16'h0, 3'd0, 1'b0, 3'd0, 16'h0, rI);
  endtask

  task automatic load(input string tag, input logic [2:0] lI, input logic [15:0] lD);
    doCycle(tag, 1'b0, 1'b0, 16'h0, 3'd0, 1'b1, lI, lD, lI);
  endtask

  task automatic acc(input string tag, input logic dbl, input logic bank, input logic [1:0] md,
                     input logic [1:0] idx, input logic [2:0] ls);
    doCycle(tag, 1'b1, dbl, mkOp(bank, md, idx), ls, 1'b0, 3'd0, 16'h0, {bank, idx});
  endtask

  // Monitor: compares design outputs mid-cycle against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (ramEn !== e.ramEn || ramBank !== e.ramBank || ramAddr !== e.ramAddr ||
            ramWe !== e.ramWe || ramWrData !== e.ramWrData || pmEn !== e.pmEn ||
            pmAddr !== e.pmAddr || accErr !== e.accErr || rdPtr !== e.rdPtr) begin
          fails++;
          $display("FAIL %s: actual en=%b bk=%b ad=%h we=%b wd=%h pe=%b pa=%h er=%b rd=%h expected en=%b bk=%b ad=%h we=%b wd=%h pe=%b pa=%h er=%b rd=%h",
                   e.tag, ramEn, ramBank, ramAddr, ramWe, ramWrData, pmEn, pmAddr, accErr, rdPtr,
                   e.ramEn, e.ramBank, e.ramAddr, e.ramWe, e.ramWrData, e.pmEn, e.pmAddr, e.accErr, e.rdPtr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) ramMem[i] = 16'h0100 + 16'(i * 7);
    ramMem[257] = 16'hFFFF;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state of every pointer, quiet outputs
    for (int i = 0; i < 8; i++) idle("R1 reset", 3'(i));

    // R9 direct loads (low byte used); R6 loads to fixed pointers ignored
    load("R9 load r0", 3'd0, 16'hAB12);
    load("R9 load r1", 3'd1, 16'h003C);
    load("R9 load r2", 3'd2, 16'h00F0);
    load("R9 load r4", 3'd4, 16'h1280);
    load("R9 load r5", 3'd5, 16'h0007);
    load("R9 load r6", 3'd6, 16'h00FF);
    load("R6 load r3 ignored", 3'd3, 16'h0055);
    load("R6 load r7 ignored", 3'd7, 16'h00AA);
    for (int i = 0; i < 8; i++) idle("R10 readback", 3'(i));

    // R2 / R3 code 00: address only, no change
    acc("R2 r1 hold", 1'b0, 1'b0, 2'b00, 2'd1, 3'd4);
    acc("R2 r5 hold bank1", 1'b0, 1'b1, 2'b00, 2'd1, 3'd3);
    idle("R3 r1 unchanged", 3'd1);
    // R3 code 01 ignores window: 0xF0->0xF1, 0xFF->0x00
    acc("R3 r2 inc free", 1'b0, 1'b0, 2'b01, 2'd2, 3'd4);
    acc("R3 r6 inc free wrap", 1'b0, 1'b1, 2'b01, 2'd2, 3'd3);
    idle("R3 r2", 3'd2);
    idle("R3 r6", 3'd6);
    // R4 code 11 with window
    acc("R4 r0 inc loop", 1'b0, 1'b0, 2'b11, 2'd0, 3'd4);
    acc("R4 r5 inc wrap", 1'b0, 1'b1, 2'b11, 2'd1, 3'd3);
    acc("R4 r4 inc no window", 1'b0, 1'b1, 2'b11, 2'd0, 3'd0);
    load("R9 load r1 3F", 3'd1, 16'h003F);
    acc("R4 r1 inc wrap keep upper", 1'b0, 1'b0, 2'b11, 2'd1, 3'd4);
    idle("R4 r1", 3'd1);
    idle("R4 r5", 3'd5);
    // R5 code 10
    acc("R5 r1 dec wrap", 1'b0, 1'b0, 2'b10, 2'd1, 3'd4);
    acc("R5 r4 dec no window", 1'b0, 1'b1, 2'b10, 2'd0, 3'd0);
    acc("R5 r4 dec again", 1'b0, 1'b1, 2'b10, 2'd0, 3'd0);
    acc("R5 r0 dec window 7", 1'b0, 1'b0, 2'b10, 2'd0, 3'd7);
    idle("R5 r1", 3'd1);
    idle("R5 r4", 3'd4);
    // R6 fixed pointers select words 0..3
    for (int m = 0; m < 4; m++) acc("R6 r3 fixed word", 1'b0, 1'b0, 2'(m), 2'd3, 3'd4);
    acc("R6 r7 fixed word 2", 1'b0, 1'b1, 2'b10, 2'd3, 3'd0);
    idle("R6 r3 still 0", 3'd3);
    idle("R6 r7 still 0", 3'd7);
    // R7 double level
    acc("R7 r0 double", 1'b1, 1'b0, 2'b00, 2'd0, 3'd0);
    acc("R7 r0 double again", 1'b1, 1'b0, 2'b00, 2'd0, 3'd0);
    acc("R7 r7 word1 FFFF", 1'b1, 1'b1, 2'b01, 2'd3, 3'd0);
    acc("R7 r7 word1 wrapped", 1'b1, 1'b1, 2'b01, 2'd3, 3'd0);
    idle("R7 r0 unchanged", 3'd0);
    // R8 invalid double-level modifiers
    acc("R8 r1 double mod11", 1'b1, 1'b0, 2'b11, 2'd1, 3'd4);
    acc("R8 r6 double mod10", 1'b1, 1'b1, 2'b10, 2'd2, 3'd0);
    idle("R8 r1 unchanged", 3'd1);
    idle("R8 r6 unchanged", 3'd6);
    // R9 load beats post-modify on same pointer
    doCycle("R9 load vs modify", 1'b1, 1'b0, mkOp(1'b0, 2'b11, 2'd2), 3'd0, 1'b1, 3'd2, 16'h0044, 3'd2);
    idle("R9 r2 loaded", 3'd2);
    idle("R9 settle", 3'd0);

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule